// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates among a parameterised set of interrupt request lines (eight by default) on behalf of one CPU. It keeps three per-level bit vectors: pending requests, a software mask and the levels currently in service. From these it chooses one winner: the highest-ranked request that is pending, not masked, and ranked above every level already in service. While such a winner exists and no acknowledge cycle is under way, it raises its interrupt output. The ranking is circular. A pointer names the lowest-ranked level, and the level just after it ranks highest. The pointer can stay fixed, move by itself when a level leaves service, or be written by software.

The CPU answers with two acknowledge strobes. The first one freezes the winner, moves it from pending to in service and drops the interrupt output. The second one returns the level number on a one-cycle vector output. If automatic end-of-interrupt is enabled, the second strobe also ends service. Otherwise software ends service with a non-specific command, which clears the top-ranked in-service level, or with a specific command that carries a level code. Each request line can be latched on its rising edge or can follow its level. All register programming arrives as single-cycle decoded strobes that carry their data alongside.

The acknowledge controller has two states. `ST_IDLE` waits for a first acknowledge, and `ST_HOLD` waits for the second. The transition ACK1 goes from `ST_IDLE` to `ST_HOLD` on the first strobe, whether or not a winner exists. The transition ACK2 goes from `ST_HOLD` back to `ST_IDLE` on the second strobe. In every other cycle the state holds.

Top module: `irq_rotator`

## Requirements
- R1: After reset the interrupt output is low, no level is masked, pending or in service, and the lowest-rank pointer is level NUM_LVL-1, so level 0 ranks highest.
- R2: With the pointer at NUM_LVL-1, lower level numbers rank higher: when levels 2 and 5 are both pending, an acknowledge returns level 2. After the pointer is written back to 7, requests on 0 and 7 give level 0.
- R3: A level whose mask bit is 1 never raises the output or wins. A mask write takes the whole vector at once. A request latched while masked is served once its mask bit is written to 0.
- R4: A pending level that ranks equal to or below the top in-service level does not raise the output. A pending level that ranks above it does, which allows nesting.
- R5: The first acknowledge strobe sets the winner's in-service bit, clears its pending bit and lowers the output until the second strobe. The cycle after the second strobe, vec_valid is high for one cycle and vec_lvl carries the level.
- R6: With cfg_level_mode at 0, a request latches on a 0-to-1 change of its line. A line held high after its acknowledge does not request again.
- R7: With cfg_level_mode at 1, the pending bit copies the line each cycle. Dropping the line before an acknowledge withdraws the request, and a line still high after its service ends requests again.
- R8: A non-specific end-of-interrupt strobe (eoi_any) clears only the top-ranked in-service bit under the current pointer.
- R9: A specific end-of-interrupt strobe (eoi_spec) clears the in-service bit named by the 3-bit code eoi_lvl.
- R10: With cfg_auto_eoi at 1, the second acknowledge strobe clears the served level's in-service bit, and no command is needed.
- R11: With cfg_auto_rot at 1, any end-of-interrupt that clears a level, whether automatic, non-specific or specific, moves the pointer to that level, so the level becomes lowest.
- R12: A prio_set strobe loads prio_lvl into the pointer. Level prio_lvl+1 (wrapping at NUM_LVL) then ranks highest, and the other levels follow in cyclic order.
- R13: An acknowledge sequence with no winner returns level NUM_LVL-1 on vec_lvl and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LVL | Request lines, bit n is level n |
| cfg_level_mode | input | 1 | 1 = level-sensitive requests, 0 = rising edge |
| cfg_auto_eoi | input | 1 | 1 = second acknowledge ends service |
| cfg_auto_rot | input | 1 | 1 = a level that leaves service becomes lowest |
| mask_wr | input | 1 | Strobe: load mask_data into the mask |
| mask_data | input | NUM_LVL | New mask, 1 = masked |
| eoi_any | input | 1 | Strobe: non-specific end of interrupt |
| eoi_spec | input | 1 | Strobe: specific end of interrupt |
| eoi_lvl | input | LW | Level code for eoi_spec |
| prio_set | input | 1 | Strobe: load the lowest-rank pointer |
| prio_lvl | input | LW | Level that becomes lowest |
| inta | input | 1 | Acknowledge strobe, one cycle per pulse |
| irq_out | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | One-cycle flag marking vec_lvl valid |
| vec_lvl | output | LW | Acknowledged level |

## Verification
The bench builds the block with NUM_LVL = 8, which makes LW 3 bits. With that size the circular ranking wraps from level 7 back to level 0. Requests on level 0 can then rank below requests on level 3 after rotation, and the spurious answer coincides with the lowest real level. Eight levels also give room for two nested in-service bits with a masked or blocked request beside them.

// File: rtl/irq_rot_pkg.sv
package irq_rot_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ack_state_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int NUM_LVL = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] irq_in,
    input  logic               level_mode,
    input  logic [NUM_LVL-1:0] clr_vec,
    output logic [NUM_LVL-1:0] irr_q
);
    logic [NUM_LVL-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= irq_in;
            if (level_mode)
                irr_q <= irq_in & ~clr_vec;
            else
                irr_q <= (irr_q | (irq_in & ~prev_q)) & ~clr_vec;
        end
    end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int NUM_LVL = 8,
    parameter int LW      = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] irr,
    input  logic [NUM_LVL-1:0] mask,
    input  logic [NUM_LVL-1:0] isr,
    input  logic [LW-1:0]      lowest,
    output logic               win_vld,
    output logic [LW-1:0]      win_lvl,
    output logic               top_vld,
    output logic [LW-1:0]      top_lvl
);
    function automatic logic [LW-1:0] rank_to_lvl(input logic [LW-1:0] low, input int rank);
        int idx;
        idx = (int'(low) + 1 + rank) % NUM_LVL;
        return LW'(idx);
    endfunction

    always_comb begin
        logic [LW-1:0] lvl;
        win_vld = 1'b0;
        win_lvl = '0;
        top_vld = 1'b0;
        top_lvl = '0;
        for (int r = 0; r < NUM_LVL; r++) begin
            lvl = rank_to_lvl(lowest, r);
            if (!win_vld && !top_vld && irr[lvl] && !mask[lvl] && !isr[lvl]) begin
                win_vld = 1'b1;
                win_lvl = lvl;
            end
            if (!top_vld && isr[lvl]) begin
                top_vld = 1'b1;
                top_lvl = lvl;
            end
        end
    end
endmodule

// File: rtl/irq_rotator.sv
module irq_rotator
    import irq_rot_pkg::*;
#(
    parameter int NUM_LVL = 8,
    localparam int LW     = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] irq_in,
    input  logic               cfg_level_mode,
    input  logic               cfg_auto_eoi,
    input  logic               cfg_auto_rot,
    input  logic               mask_wr,
    input  logic [NUM_LVL-1:0] mask_data,
    input  logic               eoi_any,
    input  logic               eoi_spec,
    input  logic [LW-1:0]      eoi_lvl,
    input  logic               prio_set,
    input  logic [LW-1:0]      prio_lvl,
    input  logic               inta,
    output logic               irq_out,
    output logic               vec_valid,
    output logic [LW-1:0]      vec_lvl
);
    localparam logic [LW-1:0] SPUR_LVL = LW'(NUM_LVL - 1);

    ack_state_e         state_q, state_d;
    logic [NUM_LVL-1:0] irr_q, mask_q, isr_q, isr_d, clr_vec;
    logic [LW-1:0]      lowest_q, lowest_d, hold_lvl_q;
    logic               hold_spur_q;
    logic               win_vld, top_vld;
    logic [LW-1:0]      win_lvl, top_lvl;
    logic               ack_first, ack_second;

    assign ack_first  = inta && (state_q == ST_IDLE);
    assign ack_second = inta && (state_q == ST_HOLD);

    irq_req_latch #(.NUM_LVL(NUM_LVL)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .level_mode (cfg_level_mode),
        .clr_vec    (clr_vec),
        .irr_q      (irr_q)
    );

    irq_prio_resolver #(.NUM_LVL(NUM_LVL), .LW(LW)) u_resolve (
        .irr     (irr_q),
        .mask    (mask_q),
        .isr     (isr_q),
        .lowest  (lowest_q),
        .win_vld (win_vld),
        .win_lvl (win_lvl),
        .top_vld (top_vld),
        .top_lvl (top_lvl)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions ACK1 and ACK2
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (inta) state_d = ST_HOLD;
            ST_HOLD: if (inta) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_out = (state_q == ST_IDLE) && win_vld;
    end

    // Service and pointer updates
    always_comb begin
        isr_d    = isr_q;
        lowest_d = lowest_q;
        clr_vec  = '0;
        if (ack_first && win_vld) begin
            isr_d[win_lvl]   = 1'b1;
            clr_vec[win_lvl] = 1'b1;
        end
        if (ack_second && cfg_auto_eoi && !hold_spur_q) begin
            isr_d[hold_lvl_q] = 1'b0;
            if (cfg_auto_rot) lowest_d = hold_lvl_q;
        end
        if (eoi_any && top_vld) begin
            isr_d[top_lvl] = 1'b0;
            if (cfg_auto_rot) lowest_d = top_lvl;
        end
        if (eoi_spec) begin
            isr_d[eoi_lvl] = 1'b0;
            if (cfg_auto_rot) lowest_d = eoi_lvl;
        end
        if (prio_set) lowest_d = prio_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q      <= '0;
            isr_q       <= '0;
            lowest_q    <= SPUR_LVL;
            hold_lvl_q  <= '0;
            hold_spur_q <= 1'b0;
            vec_valid   <= 1'b0;
            vec_lvl     <= '0;
        end else begin
            isr_q     <= isr_d;
            lowest_q  <= lowest_d;
            vec_valid <= ack_second;
            if (mask_wr) mask_q <= mask_data;
            if (ack_first) begin
                hold_lvl_q  <= win_lvl;
                hold_spur_q <= !win_vld;
            end
            if (ack_second) vec_lvl <= hold_spur_q ? SPUR_LVL : hold_lvl_q;
        end
    end
endmodule

// File: rtl/irq_rotator_chk.sv
module irq_rotator_chk
    import irq_rot_pkg::*;
#(
    parameter int NUM_LVL = 8,
    localparam int LW     = $clog2(NUM_LVL)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               inta,
    input logic               eoi_any,
    input logic               eoi_spec,
    input logic               irq_out,
    input logic               vec_valid,
    input ack_state_e         state_q,
    input logic [NUM_LVL-1:0] mask_q,
    input logic [NUM_LVL-1:0] isr_q,
    input logic               win_vld,
    input logic [LW-1:0]      win_lvl
);
    AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> !mask_q[win_lvl]); // R3

    AST_WIN_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> !isr_q[win_lvl]); // R4

    AST_ACK_SETS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && state_q == ST_IDLE && win_vld && !eoi_any && !eoi_spec) |=> isr_q[$past(win_lvl)]); // R5

    AST_QUIET_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !irq_out); // R5

    AST_VECTOR_AFTER_ACK2: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && state_q == ST_HOLD) |=> vec_valid); // R5

    AST_VECTOR_ONLY_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(state_q) == ST_HOLD); // R5

    AST_SPURIOUS_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && state_q == ST_IDLE && !win_vld && !eoi_any && !eoi_spec) |=> isr_q == $past(isr_q)); // R13
endmodule

bind irq_rotator irq_rotator_chk #(.NUM_LVL(NUM_LVL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inta      (inta),
    .eoi_any   (eoi_any),
    .eoi_spec  (eoi_spec),
    .irq_out   (irq_out),
    .vec_valid (vec_valid),
    .state_q   (state_q),
    .mask_q    (mask_q),
    .isr_q     (isr_q),
    .win_vld   (win_vld),
    .win_lvl   (win_lvl)
);

// File: tb/irq_rotator_bench.sv
module irq_rotator_bench;
    localparam int N  = 8;
    localparam int LW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          cfg_level_mode = 1'b0, cfg_auto_eoi = 1'b0, cfg_auto_rot = 1'b0;
    logic          mask_wr = 1'b0;
    logic [N-1:0]  mask_data = '0;
    logic          eoi_any = 1'b0, eoi_spec = 1'b0, prio_set = 1'b0, inta = 1'b0;
    logic [LW-1:0] eoi_lvl = '0, prio_lvl = '0;
    logic          irq_out, vec_valid;
    logic [LW-1:0] vec_lvl;

    int    n_checks = 0;
    int    n_err = 0;
    int    exp_lvl_q[$];
    string exp_tag_q[$];

    always #10 clk = ~clk;

    irq_rotator #(.NUM_LVL(N)) u_irq_rotator (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cfg_level_mode(cfg_level_mode), .cfg_auto_eoi(cfg_auto_eoi), .cfg_auto_rot(cfg_auto_rot),
        .mask_wr(mask_wr), .mask_data(mask_data),
        .eoi_any(eoi_any), .eoi_spec(eoi_spec), .eoi_lvl(eoi_lvl),
        .prio_set(prio_set), .prio_lvl(prio_lvl), .inta(inta),
        .irq_out(irq_out), .vec_valid(vec_valid), .vec_lvl(vec_lvl)
    );

    // Monitor: compare each produced vector with the next expected item
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            n_checks++;
            if (exp_lvl_q.size() == 0) begin
                n_err++;
                $display("FAIL R5 unexpected vector: actual=%0d expected=none", vec_lvl);
            end else begin
                int    e;
                string t;
                e = exp_lvl_q.pop_front();
                t = exp_tag_q.pop_front();
                if (int'(vec_lvl) != e) begin
                    n_err++;
                    $display("FAIL %s vector: actual=%0d expected=%0d", t, vec_lvl, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        n_checks++;
        if (irq_out !== exp) begin
            n_err++;
            $display("FAIL %s irq_out: actual=%b expected=%b", tag, irq_out, exp);
        end
    endtask

    // Driver: push expected level, then issue two acknowledge strobes
    task automatic do_ack(input int lvl, input string tag);
        exp_lvl_q.push_back(lvl);
        exp_tag_q.push_back(tag);
        inta = 1'b1; tick(1); inta = 1'b0; tick(1);
        inta = 1'b1; tick(1); inta = 1'b0; tick(2);
    endtask

    task automatic eoi_ns();
        eoi_any = 1'b1; tick(1); eoi_any = 1'b0; tick(1);
    endtask

    task automatic eoi_sp(input int lvl);
        eoi_lvl = LW'(lvl); eoi_spec = 1'b1; tick(1); eoi_spec = 1'b0; tick(1);
    endtask

    task automatic set_prio(input int lvl);
        prio_lvl = LW'(lvl); prio_set = 1'b1; tick(1); prio_set = 1'b0; tick(1);
    endtask

    task automatic wr_mask(input logic [N-1:0] m);
        mask_data = m; mask_wr = 1'b1; tick(1); mask_wr = 1'b0; tick(1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk_irq("R1", 1'b0);

        // Fixed order, nesting, end-of-interrupt commands
        irq_in[5] = 1'b1; irq_in[2] = 1'b1; tick(2);
        chk_irq("R2", 1'b1);
        do_ack(2, "R2");
        chk_irq("R4 lower blocked", 1'b0);
        irq_in[1] = 1'b1; tick(2);
        chk_irq("R4 higher nests", 1'b1);
        do_ack(1, "R4");
        eoi_ns();
        chk_irq("R8 only top cleared", 1'b0);
        eoi_ns();
        chk_irq("R8 second clear", 1'b1);
        do_ack(5, "R8");
        eoi_sp(5);
        chk_irq("R6 held lines silent", 1'b0);
        irq_in[6] = 1'b1; tick(2);
        chk_irq("R9 level 5 released", 1'b1);
        do_ack(6, "R9");
        eoi_sp(6);
        irq_in = '0; tick(2);

        // Mask
        wr_mask(8'h08);
        irq_in[3] = 1'b1; tick(2);
        chk_irq("R3 masked", 1'b0);
        wr_mask(8'h00); tick(1);
        chk_irq("R3 unmasked", 1'b1);
        do_ack(3, "R3");
        eoi_ns();
        irq_in = '0; tick(2);

        // Spurious acknowledge
        do_ack(7, "R13");
        chk_irq("R13 idle after spurious", 1'b0);
        irq_in[7] = 1'b1; tick(2);
        chk_irq("R13 no service set", 1'b1);
        do_ack(7, "R13");
        eoi_ns();
        irq_in = '0; tick(2);

        // Level mode
        cfg_level_mode = 1'b1;
        irq_in[4] = 1'b1; tick(2);
        chk_irq("R7 follows high", 1'b1);
        irq_in[4] = 1'b0; tick(2);
        chk_irq("R7 withdrawn", 1'b0);
        irq_in[4] = 1'b1; tick(2);
        do_ack(4, "R7");
        eoi_ns(); tick(1);
        chk_irq("R7 re-request", 1'b1);
        irq_in[4] = 1'b0; tick(2);
        chk_irq("R7 dropped", 1'b0);
        cfg_level_mode = 1'b0; tick(2);

        // Automatic end of interrupt
        cfg_auto_eoi = 1'b1;
        irq_in[6] = 1'b1; irq_in[1] = 1'b1; tick(2);
        do_ack(1, "R10");
        chk_irq("R10 service ended", 1'b1);
        do_ack(6, "R10");
        chk_irq("R10 all served", 1'b0);
        cfg_auto_eoi = 1'b0;
        irq_in = '0; tick(2);

        // Automatic rotation
        cfg_auto_rot = 1'b1;
        irq_in[2] = 1'b1; tick(2);
        do_ack(2, "R11");
        eoi_ns();
        irq_in = '0; tick(2);
        irq_in[0] = 1'b1; irq_in[3] = 1'b1; tick(2);
        do_ack(3, "R11 rotated after 2");
        eoi_ns();
        do_ack(0, "R11");
        eoi_ns();
        cfg_auto_rot = 1'b0;
        irq_in = '0; tick(2);

        // Specific rotation
        set_prio(4);
        irq_in[2] = 1'b1; irq_in[6] = 1'b1; tick(2);
        do_ack(6, "R12");
        eoi_ns();
        do_ack(2, "R12");
        eoi_ns();
        irq_in = '0; tick(2);
        set_prio(7);
        irq_in[0] = 1'b1; irq_in[7] = 1'b1; tick(2);
        do_ack(0, "R2 wrap restored");
        eoi_ns();
        do_ack(7, "R2");
        eoi_ns();
        irq_in = '0; tick(3);

        n_checks++;
        if (exp_lvl_q.size() != 0) begin
            n_err++;
            $display("FAIL R5 vectors missing: actual=%0d left expected=0", exp_lvl_q.size());
        end
        finish_run();
    end
endmodule